// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

A 32-pin general-purpose I/O bank that sits behind a plain 32-bit memory-mapped register port: a byte address, a write strobe, write data and a combinational read-data return. The bank drives pin output values and output enables from software-owned registers. It brings the external pin levels through a two-flop synchronizer, and it raises an interrupt per pin on a level or an edge of either polarity, or on both edges.

Every 32-bit logical register is split across two adjacent word addresses. The lower word carries pins 0 to 15 and the higher word carries pins 16 to 31, each in data bits [15:0]. On a write, the upper sixteen bits of the bus word act as a per-bit write enable, so software can change single pins without a read-modify-write sequence. Edge events are latched until software acknowledges them through a write-only acknowledge register. Level events simply follow the synchronized pin. A single active-high line reports whether any unmasked, enabled pin is pending.

Top module: `gpio_irq_bank`

## Requirements
- R1: Each logical register occupies two words. Byte offset base+0 holds pins 0..15 and base+4 holds pins 16..31, both in read bits [15:0], and read bits [31:16] are always zero. The bases are: output value 0x00, direction 0x08, interrupt enable 0x10, interrupt mask 0x18, trigger type 0x20, polarity 0x28, both-edge 0x30, filter enable 0x38, masked status 0x50, raw status 0x58, acknowledge 0x60, synchronized input 0x70.
- R2: On a write to a half, data bit k (k in 0..15) is stored only when write bit k+16 is 1. Bits whose enable is 0 keep their previous value.
- R3: pin_out equals the output value register, and pin_oe equals the direction register, where 1 means the pin is driven.
- R4: The synchronized-input register returns pin_in through two flops. A change made just after a rising clock edge is still invisible after one more rising edge and is readable after two.
- R5: With trigger type 0 (level), an enabled pin's raw status is 1 while the synchronized pin equals its polarity bit (1 = active-high, 0 = active-low). It is not latched, and an acknowledge write leaves it unchanged.
- R6: With trigger type 1 (edge) and both-edge 0, polarity 1 latches on a rising edge and polarity 0 latches on a falling edge, the edge being taken between successive synchronized samples. The opposite edge does not set the status, and a latched bit holds until it is acknowledged.
- R7: With trigger type 1 and both-edge 1, an enabled pin latches on either edge whatever its polarity bit.
- R8: Writing the acknowledge register clears latched edge bits where both the data bit and its enable bit (bit k+16) are 1. The register reads as zero. A new edge in the same cycle as its acknowledge leaves the bit set.
- R9: Raw status is zero for pins whose enable bit is 0, and disabling a pin drops its latched edge. Masked status equals raw status with mask-1 pins forced to 0, and the mask does not change raw status.
- R10: irq is 1 exactly when any masked-status bit is 1.
- R11: After reset every register reads zero, all pins are inputs with pin_out zero, and irq is 0.
- R12: The filter-enable register is stored and read back like the other configuration registers and has no effect on detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| bus_rdata | output | 32 | Read word for bus_addr, combinational |
| pin_in | input | 32 | External pin levels, asynchronous |
| pin_out | output | 32 | Output values toward the pads |
| pin_oe | output | 32 | Output enables toward the pads |
| irq | output | 1 | Active-high bank interrupt |

## Verification
The hardest case to reach from the ports is an acknowledge landing in the very cycle that a fresh edge on the same pin is being latched, since the edge only appears two clock edges after the pin moves. The stimulus changes the pin right after a clock edge, lets exactly two rising edges pass, and issues the acknowledge write so that its edge coincides with the detection, then expects the bit to remain set. A rising edge on a pin with polarity 0 shows that the both-edge bit overrides polarity. An acknowledge with its enable bits cleared shows that the write mask also governs clears.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Word selector: byte address bits [7:3]. Bit 2 picks the pin half.
    typedef enum logic [4:0] {
        SEL_DOUT = 5'd0,
        SEL_DIR  = 5'd1,
        SEL_IEN  = 5'd2,
        SEL_IMSK = 5'd3,
        SEL_ITYP = 5'd4,
        SEL_IPOL = 5'd5,
        SEL_BOTH = 5'd6,
        SEL_FILT = 5'd7,
        SEL_STAT = 5'd10,
        SEL_RAW  = 5'd11,
        SEL_ACK  = 5'd12,
        SEL_EXT  = 5'd14
    } reg_sel_e;

    localparam int SEL_W = 5;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_async;
            s2_q <= s1_q;
        end
    end

    assign q_sync = s2_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_sync,
    input  logic [NPINS-1:0] ien,
    input  logic [NPINS-1:0] ityp,
    input  logic [NPINS-1:0] ipol,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] ack_clr,
    output logic [NPINS-1:0] raw_st
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] edg;
    } det_t;

    det_t det_d, det_q;
    logic [NPINS-1:0] hit;

    // Per-pin edge qualifier
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise, fall;
        assign rise   = pin_sync[i] & ~det_q.prev[i];
        assign fall   = ~pin_sync[i] & det_q.prev[i];
        assign hit[i] = both[i] ? (rise | fall) : (ipol[i] ? rise : fall);
    end

    always_comb begin
        det_d      = det_q;
        det_d.prev = pin_sync;
        // a new edge wins over a same-cycle acknowledge
        det_d.edg  = ien & ityp & ((det_q.edg & ~ack_clr) | hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign raw_st = ien & ((ityp & det_q.edg) | (~ityp & ~(pin_sync ^ ipol)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [2*HALF_W-1:0] bus_wdata,
    output logic [2*HALF_W-1:0] bus_rdata,
    input  logic [2*HALF_W-1:0] pin_in,
    output logic [2*HALF_W-1:0] pin_out,
    output logic [2*HALF_W-1:0] pin_oe,
    output logic                irq
);
    localparam int NPINS  = 2 * HALF_W;
    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] imsk;
        logic [NPINS-1:0] ityp;
        logic [NPINS-1:0] ipol;
        logic [NPINS-1:0] both;
        logic [NPINS-1:0] filt;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [SEL_W-1:0] word_sel;
    logic             upper;
    logic [NPINS-1:0] pin_sync, raw_st, mst, ack_clr;

    assign word_sel = bus_addr[SEL_W+2:3];
    assign upper    = bus_addr[2];

    // Bit-enabled merge of one half of a write word into a pin vector
    function automatic logic [NPINS-1:0] merge(input logic [NPINS-1:0] old,
                                               input logic             hi,
                                               input logic [WORD_W-1:0] wd);
        logic [NPINS-1:0] m, v;
        m = '0;
        v = '0;
        if (hi) begin
            m[NPINS-1:HALF_W] = wd[WORD_W-1:HALF_W];
            v[NPINS-1:HALF_W] = wd[HALF_W-1:0];
        end else begin
            m[HALF_W-1:0] = wd[WORD_W-1:HALF_W];
            v[HALF_W-1:0] = wd[HALF_W-1:0];
        end
        return (old & ~m) | (v & m);
    endfunction

    function automatic logic [WORD_W-1:0] pick(input logic [NPINS-1:0] v,
                                               input logic             hi);
        return {{HALF_W{1'b0}}, (hi ? v[NPINS-1:HALF_W] : v[HALF_W-1:0])};
    endfunction

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .ien      (cfg_q.ien),
        .ityp     (cfg_q.ityp),
        .ipol     (cfg_q.ipol),
        .both     (cfg_q.both),
        .ack_clr  (ack_clr),
        .raw_st   (raw_st)
    );

    always_comb begin
        cfg_d   = cfg_q;
        ack_clr = '0;
        if (bus_we) begin
            case (word_sel)
                SEL_W'(SEL_DOUT): cfg_d.dout = merge(cfg_q.dout, upper, bus_wdata);
                SEL_W'(SEL_DIR):  cfg_d.dir  = merge(cfg_q.dir,  upper, bus_wdata);
                SEL_W'(SEL_IEN):  cfg_d.ien  = merge(cfg_q.ien,  upper, bus_wdata);
                SEL_W'(SEL_IMSK): cfg_d.imsk = merge(cfg_q.imsk, upper, bus_wdata);
                SEL_W'(SEL_ITYP): cfg_d.ityp = merge(cfg_q.ityp, upper, bus_wdata);
                SEL_W'(SEL_IPOL): cfg_d.ipol = merge(cfg_q.ipol, upper, bus_wdata);
                SEL_W'(SEL_BOTH): cfg_d.both = merge(cfg_q.both, upper, bus_wdata);
                SEL_W'(SEL_FILT): cfg_d.filt = merge(cfg_q.filt, upper, bus_wdata);
                SEL_W'(SEL_ACK):  ack_clr    = merge('0, upper, bus_wdata);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mst = raw_st & ~cfg_q.imsk;

    always_comb begin
        case (word_sel)
            SEL_W'(SEL_DOUT): bus_rdata = pick(cfg_q.dout, upper);
            SEL_W'(SEL_DIR):  bus_rdata = pick(cfg_q.dir,  upper);
            SEL_W'(SEL_IEN):  bus_rdata = pick(cfg_q.ien,  upper);
            SEL_W'(SEL_IMSK): bus_rdata = pick(cfg_q.imsk, upper);
            SEL_W'(SEL_ITYP): bus_rdata = pick(cfg_q.ityp, upper);
            SEL_W'(SEL_IPOL): bus_rdata = pick(cfg_q.ipol, upper);
            SEL_W'(SEL_BOTH): bus_rdata = pick(cfg_q.both, upper);
            SEL_W'(SEL_FILT): bus_rdata = pick(cfg_q.filt, upper);
            SEL_W'(SEL_STAT): bus_rdata = pick(mst,        upper);
            SEL_W'(SEL_RAW):  bus_rdata = pick(raw_st,     upper);
            SEL_W'(SEL_EXT):  bus_rdata = pick(pin_sync,   upper);
            default:          bus_rdata = '0;
        endcase
    end

    assign pin_out = cfg_q.dout;
    assign pin_oe  = cfg_q.dir;
    assign irq     = |mst;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [2*HALF_W-1:0] bus_wdata,
    input logic [2*HALF_W-1:0] bus_rdata,
    input logic [2*HALF_W-1:0] pin_oe,
    input logic                irq,
    input logic [2*HALF_W-1:0] raw_st,
    input logic [2*HALF_W-1:0] mst,
    input logic [2*HALF_W-1:0] ien,
    input logic [2*HALF_W-1:0] imsk,
    input logic [2*HALF_W-1:0] ityp,
    input logic [2*HALF_W-1:0] ack_clr
);
    localparam int NPINS = 2 * HALF_W;

    p_irq_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(raw_st & ien & ~imsk));

    p_mask_hides_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mst & imsk) == '0);

    p_ack_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[SEL_W+2:3] == SEL_W'(SEL_ACK)) |-> bus_rdata == '0);

    p_dir_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h08) && bus_wdata[2*HALF_W-1:HALF_W] == '1)
        |=> pin_oe[HALF_W-1:0] == $past(bus_wdata[HALF_W-1:0]));

    p_edge_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw_st & ityp & ien) & ~$past(ack_clr)) & ityp & ien & ~raw_st)
                 == {NPINS{1'b0}});

    p_reset_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && irq == 1'b0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .raw_st    (raw_st),
    .mst       (mst),
    .ien       (cfg_q.ien),
    .imsk      (cfg_q.imsk),
    .ityp      (cfg_q.ityp),
    .ack_clr   (ack_clr)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [31:0] w;
        logic [31:0] r;
    } vec_t;

    // write, then read back the same word
    localparam vec_t TBL [9] = '{
        '{8'h00, 32'hFFFF_A5A5, 32'h0000_A5A5},  // R1 low half
        '{8'h00, 32'h00F0_FFFF, 32'h0000_A5F5},  // R2 set bits 4..7 only
        '{8'h00, 32'h000F_0000, 32'h0000_A5F0},  // R2 clear bits 0..3 only
        '{8'h04, 32'hFFFF_1234, 32'h0000_1234},  // R1 high half
        '{8'h08, 32'hFFFF_00FF, 32'h0000_00FF},  // R3 direction
        '{8'h08, 32'h0000_FFFF, 32'h0000_00FF},  // R2 empty enable
        '{8'h3C, 32'hFFFF_8001, 32'h0000_8001},  // R12 filter enable
        '{8'h60, 32'hFFFF_FFFF, 32'h0000_0000},  // R8 acknowledge reads zero
        '{8'h70, 32'hFFFF_FFFF, 32'h0000_0000}   // R4 input word not writable
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #2;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: every word reads zero after reset
        for (int k = 0; k < 30; k++) begin
            bus_rd(8'(k * 4), rd);
            check("R11 reg", rd, 32'h0);
        end
        check("R11 pin_oe", pin_oe, 32'h0);
        check("R11 pin_out", pin_out, 32'h0);
        check("R11 irq", {31'h0, irq}, 32'h0);

        // R4: two-flop input path
        @(negedge clk) pin_in = 32'hDEAD_BEEF;
        bus_rd(8'h70, rd); check("R4 one edge", rd, 32'h0);
        bus_rd(8'h70, rd); check("R4 low half", rd, 32'h0000_BEEF);
        bus_rd(8'h74, rd); check("R4 high half", rd, 32'h0000_DEAD);
        pin_in = '0;
        wait_cyc(4);

        // R1 R2 R3 R12: vector table
        for (int k = 0; k < 9; k++) begin
            bus_wr(TBL[k].a, TBL[k].w);
            bus_rd(TBL[k].a, rd);
            check($sformatf("R1/R2 vec %0d", k), rd, TBL[k].r);
        end
        check("R3 pin_out", pin_out, 32'h1234_A5F0);
        check("R3 pin_oe", pin_oe, 32'h0000_00FF);

        // interrupt scenarios
        do_reset();
        bus_wr(8'h20, 32'hFFFF_000E); // edge on pins 1,2,3
        bus_wr(8'h28, 32'hFFFF_0003); // pin0 high level, pin1 rising
        bus_wr(8'h30, 32'hFFFF_0008); // pin3 both edges
        bus_wr(8'h10, 32'hFFFF_000F);
        bus_wr(8'h14, 32'hFFFF_0010); // pin20 level low
        wait_cyc(4);
        bus_rd(8'h58, rd); check("R5 lo idle", rd, 32'h0);
        bus_rd(8'h5C, rd); check("R5 active-low", rd, 32'h0010);
        bus_rd(8'h54, rd); check("R9 status hi", rd, 32'h0010);
        check("R10 irq", {31'h0, irq}, 32'h1);

        pin_in = 32'h0010_000B;
        wait_cyc(4);
        bus_rd(8'h58, rd); check("R6 rise/R5 high", rd, 32'h000B);
        bus_rd(8'h5C, rd); check("R5 low released", rd, 32'h0);

        pin_in = 32'h0;
        wait_cyc(4);
        bus_rd(8'h58, rd); check("R6 latched", rd, 32'h000A);
        bus_rd(8'h5C, rd); check("R5 low again", rd, 32'h0010);

        pin_in[2] = 1'b1;
        wait_cyc(4);
        bus_rd(8'h58, rd); check("R6 wrong edge", rd, 32'h000A);
        pin_in[2] = 1'b0;
        wait_cyc(4);
        bus_rd(8'h58, rd); check("R6 falling", rd, 32'h000E);

        bus_wr(8'h60, 32'h0002_0002);
        bus_rd(8'h58, rd); check("R8 ack pin1", rd, 32'h000C);
        bus_wr(8'h60, 32'h0000_0004);
        bus_rd(8'h58, rd); check("R8 ack no enable", rd, 32'h000C);
        bus_wr(8'h60, 32'h0004_0004);
        bus_rd(8'h58, rd); check("R8 ack pin2", rd, 32'h0008);
        bus_wr(8'h64, 32'h0010_0010);
        bus_rd(8'h5C, rd); check("R5 ack ignored", rd, 32'h0010);

        bus_wr(8'h18, 32'hFFFF_0008);
        bus_rd(8'h50, rd); check("R9 masked", rd, 32'h0);
        bus_rd(8'h58, rd); check("R9 raw kept", rd, 32'h0008);
        check("R10 irq hi pending", {31'h0, irq}, 32'h1);
        bus_wr(8'h1C, 32'hFFFF_0010);
        @(negedge clk);
        check("R10 irq all masked", {31'h0, irq}, 32'h0);
        bus_wr(8'h18, 32'hFFFF_0000);
        bus_wr(8'h1C, 32'hFFFF_0000);
        @(negedge clk);
        check("R10 irq unmasked", {31'h0, irq}, 32'h1);

        bus_wr(8'h10, 32'h0008_0000);
        bus_rd(8'h58, rd); check("R9 disabled", rd, 32'h0);

        // R8: acknowledge coincides with a new rising edge on pin1
        @(negedge clk) pin_in[1] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        bus_wr(8'h60, 32'h0002_0002);
        bus_rd(8'h58, rd); check("R8 edge wins", rd, 32'h0002);
        bus_wr(8'h60, 32'h0002_0002);
        bus_rd(8'h58, rd); check("R8 later ack", rd, 32'h0);

        // R7: both-edge pin3 with polarity 0 also catches rising
        bus_wr(8'h10, 32'h0008_0008);
        pin_in[3] = 1'b1;
        wait_cyc(4);
        bus_rd(8'h58, rd); check("R7 rising", rd, 32'h0008);
        bus_wr(8'h60, 32'h0008_0008);
        pin_in[3] = 1'b0;
        wait_cyc(4);
        bus_rd(8'h58, rd); check("R7 falling", rd, 32'h0008);
        bus_wr(8'h60, 32'h0008_0008);

        // R5: level pin follows the pin, ack has no effect
        pin_in[0] = 1'b1;
        wait_cyc(4);
        bus_rd(8'h58, rd); check("R5 high level", rd, 32'h0001);
        bus_wr(8'h60, 32'h0001_0001);
        bus_rd(8'h58, rd); check("R5 ack no effect", rd, 32'h0001);
        pin_in[0] = 1'b0;
        wait_cyc(4);
        bus_rd(8'h58, rd); check("R5 not latched", rd, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule